// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is a small control sequencer whose behaviour lives entirely in a read-only table of microwords. A state register holds the current microword address. Each microword drives a bank of control outputs and holds two jump addresses. Every clock edge moves the sequencer to a new address. Two condition inputs pick that address: the next address in sequence (current plus one), or one of the two jump addresses stored in the current word. No opcode or select field exists in the word. The raw conditions make the choice directly.

The table contents are fixed when the block is built, through a parameter that packs all words into one vector. The surrounding logic reads the control outputs and the current address. To change the behaviour, a new table is supplied. The logic stays the same.

Top module: `mseq_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state register loads address 0. After that edge, `upc` reads 0 and `ctrl_out` shows the output field of word 0.
- R2: When `cond` is 2'b00 at a rising edge (reset low), the state advances to the current address plus one.
- R3: Sequential advance wraps: from the highest address (DEPTH-1), `cond` 2'b00 moves the state to address 0.
- R4: When `cond` is 2'b01 at a rising edge (reset low), the state loads target A of the word at the current address.
- R5: When `cond` is 2'b10 or 2'b11 at a rising edge (reset low), the state loads target B of the word at the current address. Both codes give the same result.
- R6: `ctrl_out` always equals the output field of the word addressed by `upc`. It follows in the same cycle the state changes, with no extra register stage.
- R7: Reset is synchronous and overrides the conditions. Raising `rst` between edges leaves `upc` unchanged until the next rising edge. At that edge the state goes to 0 whatever `cond` holds.
- R8: Word layout, with the least significant bit first: bits [OUT_W-1:0] are the control outputs, the next ADDR_W bits are target A, and the top ADDR_W bits are target B. Word i occupies bits [i*WORD_W +: WORD_W] of `UCODE`. With the defaults, this is [7:0] outputs, [11:8] target A and [15:12] target B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to address 0 |
| cond | input | 2 | Condition inputs that choose the next address |
| upc | output | ADDR_W | Current microword address (state register) |
| ctrl_out | output | OUT_W | Control output field of the current microword |

## Verification
The in-line properties check every cycle that the new state matches the rule for the condition code seen at the previous edge. This covers sequential advance with wrap, the target A jump and the target B jump for both upper codes. They also check that reset lands on address 0 and that the outputs hold steady whenever the address does. Some behaviours depend on a concrete table, and only the directed scenarios show them. These are the exact output word at each address, the bit positions of the word fields, and the fact that an asynchronous-looking mid-cycle reset has no effect before the edge. The bench runs a known table against a reference model to check these.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

   typedef enum logic [1:0] {
      PICK_SEQ = 2'd0,
      PICK_TGT_A = 2'd1,
      PICK_TGT_B = 2'd2
   } pick_e;

   // Condition code to next-address source: 00 sequential, 01 target A,
   // 10 and 11 both target B.
   function automatic pick_e decode_pick(input logic [1:0] c);
      pick_e p;
      unique case (c)
         2'b00: p = PICK_SEQ;
         2'b01: p = PICK_TGT_A;
         default: p = PICK_TGT_B;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/mseq_store.sv
module mseq_store #(
   parameter int ADDR_W = 4,
   parameter int OUT_W = 8,
   parameter int WORD_W = OUT_W + 2 * ADDR_W,
   parameter int DEPTH = 1 << ADDR_W,
   parameter logic [DEPTH*WORD_W-1:0] UCODE = '0
) (
   input logic [ADDR_W-1:0] addr,
   output logic [OUT_W-1:0] ctrl,
   output logic [ADDR_W-1:0] tgt_a,
   output logic [ADDR_W-1:0] tgt_b
);

   localparam int TA_LSB = OUT_W;
   localparam int TB_LSB = OUT_W + ADDR_W;

   if (WORD_W != OUT_W + 2 * ADDR_W) begin : g_bad_word_w
      $error("mseq_store: WORD_W must equal OUT_W + 2*ADDR_W");
   end

   logic [WORD_W-1:0] rom [DEPTH];
   logic [WORD_W-1:0] word;

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      assign rom[i] = UCODE[i*WORD_W +: WORD_W];
   end

   assign word = rom[addr];
   assign ctrl = word[OUT_W-1:0];
   assign tgt_a = word[TA_LSB +: ADDR_W];
   assign tgt_b = word[TB_LSB +: ADDR_W];

endmodule

// File: rtl/mseq_next_addr.sv
module mseq_next_addr
   import mseq_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input logic [ADDR_W-1:0] cur,
   input logic [ADDR_W-1:0] tgt_a,
   input logic [ADDR_W-1:0] tgt_b,
   input logic [1:0] cond,
   output logic [ADDR_W-1:0] nxt
);

   logic [ADDR_W-1:0] inc;
   pick_e pick;

   // Width-limited sum: the top address rolls over to zero.
   assign inc = cur + ADDR_W'(1);
   assign pick = decode_pick(cond);

   always_comb begin
      unique case (pick)
         PICK_SEQ: nxt = inc;
         PICK_TGT_A: nxt = tgt_a;
         default: nxt = tgt_b;
      endcase
   end

endmodule

// File: rtl/mseq_state_reg.sv
module mseq_state_reg #(
   parameter int ADDR_W = 4
) (
   input logic clk,
   input logic rst,
   input logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else q <= d;
   end

   assert_reset_to_zero_R1: assert property (@(posedge clk)
      rst |=> (q == '0))
      else $error("state not zero after reset edge");

endmodule

// File: rtl/mseq_sequencer.sv
module mseq_sequencer #(
   parameter int ADDR_W = 4,
   parameter int OUT_W = 8,
   parameter logic [(1<<ADDR_W)*(OUT_W+2*ADDR_W)-1:0] UCODE = '0
) (
   input logic clk,
   input logic rst,
   input logic [1:0] cond,
   output logic [ADDR_W-1:0] upc,
   output logic [OUT_W-1:0] ctrl_out
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam int WORD_W = OUT_W + 2 * ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr_w
      $error("mseq_sequencer: ADDR_W must be 1..10");
   end
   if (OUT_W < 1) begin : g_bad_out_w
      $error("mseq_sequencer: OUT_W must be at least 1");
   end

   logic [ADDR_W-1:0] state_q;
   logic [ADDR_W-1:0] next_addr;
   logic [ADDR_W-1:0] tgt_a;
   logic [ADDR_W-1:0] tgt_b;

   mseq_store #(
      .ADDR_W(ADDR_W), .OUT_W(OUT_W), .WORD_W(WORD_W), .DEPTH(DEPTH), .UCODE(UCODE)
   ) u_store (
      .addr(state_q), .ctrl(ctrl_out), .tgt_a(tgt_a), .tgt_b(tgt_b)
   );

   mseq_next_addr #(.ADDR_W(ADDR_W)) u_next (
      .cur(state_q), .tgt_a(tgt_a), .tgt_b(tgt_b), .cond(cond), .nxt(next_addr)
   );

   mseq_state_reg #(.ADDR_W(ADDR_W)) u_state (
      .clk(clk), .rst(rst), .d(next_addr), .q(state_q)
   );

   assign upc = state_q;

   // R2 and R3: sequential step, truncated so the top address wraps.
   assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
      (cond == 2'b00) |=> (upc == ADDR_W'($past(upc) + 1'b1)))
      else $error("sequential advance wrong");

   assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (rst)
      (cond == 2'b00 && upc == ADDR_W'(DEPTH - 1)) |=> (upc == '0))
      else $error("wrap from top address wrong");

   assert_jump_a_R4: assert property (@(posedge clk) disable iff (rst)
      (cond == 2'b01) |=> (upc == $past(tgt_a)))
      else $error("target A jump wrong");

   assert_jump_b_R5: assert property (@(posedge clk) disable iff (rst)
      cond[1] |=> (upc == $past(tgt_b)))
      else $error("target B jump wrong");

   assert_out_follows_addr_R6: assert property (@(posedge clk) disable iff (rst)
      $stable(upc) |-> $stable(ctrl_out))
      else $error("outputs moved without address change");

endmodule

// File: tb/mseq_sequencer_bench.sv
`timescale 1ns/1ps
module mseq_sequencer_bench;

   localparam int AW = 4;
   localparam int OW = 8;
   localparam int N = 1 << AW;
   localparam int WW = OW + 2 * AW;

   function automatic logic [OW-1:0] f_out(input int i);
      return OW'((i * 29) ^ 8'h5A);
   endfunction
   function automatic logic [AW-1:0] f_ta(input int i);
      return AW'(i + 5);
   endfunction
   function automatic logic [AW-1:0] f_tb(input int i);
      return AW'(i * 3 + 2);
   endfunction
   // R8 layout: {target B, target A, outputs}, word i at [i*WW +: WW].
   function automatic logic [N*WW-1:0] build_prog();
      logic [N*WW-1:0] v;
      v = '0;
      for (int i = 0; i < N; i++) v[i*WW +: WW] = {f_tb(i), f_ta(i), f_out(i)};
      return v;
   endfunction
   localparam logic [N*WW-1:0] PROG = build_prog();

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [1:0] cond = 2'b00;
   logic [AW-1:0] upc;
   logic [OW-1:0] ctrl_out;

   int n_checks = 0;
   int n_errors = 0;
   int model = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mseq_sequencer #(.ADDR_W(AW), .OUT_W(OW), .UCODE(PROG)) u_mseq_sequencer (
      .clk(clk), .rst(rst), .cond(cond), .upc(upc), .ctrl_out(ctrl_out)
   );

   task automatic check(input string req, input int exp_addr);
      n_checks++;
      if (upc !== AW'(exp_addr) || ctrl_out !== f_out(exp_addr)) begin
         n_errors++;
         $display("FAIL %s: addr=%0d out=%02h expected addr=%0d out=%02h",
                  req, upc, ctrl_out, exp_addr, f_out(exp_addr));
      end
   endtask

   // Called at a negedge: apply condition, take one edge, check at next negedge.
   task automatic step(input logic [1:0] c, input string req);
      cond = c;
      @(posedge clk);
      if (rst) model = 0;
      else if (c == 2'b00) model = (model + 1) % N;
      else if (c == 2'b01) model = int'(f_ta(model));
      else model = int'(f_tb(model));
      @(negedge clk);
      check(req, model);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      step(2'b01, "R1");
      step(2'b10, "R1");
      rst = 1'b0;
   endtask

   task automatic t_sequential();
      for (int k = 0; k < 20; k++) step(2'b00, (model == N - 1) ? "R3" : "R2");
   endtask

   task automatic t_jump_a();
      for (int k = 0; k < 6; k++) step(2'b01, "R4");
   endtask

   task automatic t_jump_b();
      for (int k = 0; k < 4; k++) step(2'b10, "R5");
      for (int k = 0; k < 4; k++) step(2'b11, "R5");
   endtask

   task automatic t_mixed();
      logic [1:0] pat [8] = '{2'b00, 2'b01, 2'b11, 2'b00, 2'b10, 2'b01, 2'b00, 2'b11};
      for (int k = 0; k < 24; k++) step(pat[k % 8], "R6 R8");
   endtask

   task automatic t_reset_sync();
      if (model == 0) step(2'b00, "R2");
      rst = 1'b1;
      cond = 2'b01;
      #5;
      check("R7", model);
      step(2'b01, "R7");
      rst = 1'b0;
      step(2'b00, "R2");
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_sequential();
      t_jump_a();
      t_jump_b();
      t_mixed();
      t_reset_sync();
      t_reset();
      t_mixed();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(20 * 5000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule